// File: doc/BRIEF.md
# Buffered Timer/Counter with Compare, PWM and Capture

This block is a timer/counter whose width is set by a parameter (16 bits by default). It has a period register and up to four compare/capture channels. The counter steps once on each cycle in which the `tick` enable is high. The counter runs in one of three modes:

- free counting, up or down;
- single-slope PWM;
- dual-slope (up then down) PWM.

Software sets the period and compare values through a small register write port. These writes land in shadow buffers. The running values change only at the update point of the counting cycle, so the waveforms never glitch when settings change.

Any channel can instead record the count when an external event occurs. Two capture schemes are provided. In frequency capture, each rising event edge records the count and restarts the counter. In pulse-width capture, the rising edge restarts the counter and the falling edge records it. An overflow flag and one flag per channel give sticky indications that software clears by writing ones.

Registers are read through a combinational read port. Addresses are 4 bits wide.

| Address | Register | Meaning |
|---------|----------|---------|
| 0 | control | mode, direction, capture scheme, capture enables |
| 1 | command | write-only actions; always reads zero |
| 2 | count | the counter value |
| 3 | period | reads the live period; a write goes to the period buffer |
| 4 | period buffer | reads the buffered period |
| 5..8 | channel compare, channels 0..3 | reads the live compare value; a write goes to the channel buffer |
| 9..12 | channel buffer, channels 0..3 | reads the buffered value |
| 13 | flags | sticky status flags |

Top module: `dbuf_timer`

## Requirements
- R1: After reset the registers read as follows: count 0, period 0xFFFF, every compare and buffer 0, control 0, flags 0. All waveform outputs are low.
- R2: Control bits [1:0] select the mode: 0 = free count, 1 = single-slope PWM, 2 = dual-slope PWM. In free count, control bit 2 set to 0 means count up: each tick adds one, and a tick at or above the period gives 0 and sets the overflow flag. Bit 2 set to 1 means count down: a tick at 0 loads the period and sets the overflow flag.
- R3: A write to address 3 or to addresses 5..8 changes only the buffer and sets that buffer's valid flag. In the flags register, bit 5 is the period-buffer valid flag and bits 6+n are the valid flags for channel n. The live value is unchanged until the next update.
- R4: An update happens at each wrap in free count and single-slope modes, at the bottom turn in dual-slope mode, and on command bit 0. At an update, every valid buffer is copied to its live register and its valid flag clears.
- R5: Command bit 1 restarts the counter: the count goes to 0 and the waveforms go low. Command bit 2 returns every register to its reset value. Address 1 always reads 0.
- R6: In single-slope mode the counter counts 0..period. A channel output goes high when the count reaches 0 and goes low when the count equals its compare value, so a compare of 0 keeps the output low and a compare above the period keeps it high.
- R7: In dual-slope mode the count rises 0..period and falls back to 0. A channel output toggles each time the new count equals its compare value. Leaving the bottom sets the overflow flag.
- R8: In both PWM modes a period below 3 acts as 3. In free count the period is used as written.
- R9: A compare match sets channel flag n (flags bit 1+n). The overflow flag is flags bit 0. Writing a 1 to a bit among flags bits [4:0] clears that flag. Flags are sticky otherwise, and each flag is also driven on its interrupt output.
- R10: Control bits [4:3] set to 1 select frequency capture on the channels enabled in control bits [8:5]. On each rising edge of `cap_evt`, the current count goes into the channel buffer, the buffer valid flag and the channel flag are set, and the counter restarts, counting that cycle's tick. The captured value therefore equals the number of ticks between edges.
- R11: Control bits [4:3] set to 2 select pulse-width capture. A rising edge restarts the counter as in R10. A falling edge records the count into the enabled channels' buffers and sets their valid flags and channel flags.
- R12: A capture-enabled channel does not compare, and an update does not copy its buffer into its live compare register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable, one step per high cycle |
| cap_evt | input | 1 | Capture event level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | W | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | W | Read data (combinational) |
| wave_o | output | NCH | Channel waveform outputs |
| ovf_irq | output | 1 | Overflow/underflow flag |
| ch_irq | output | NCH | Channel compare/capture flags |

## Verification
The checker watches several rules on every cycle:

- the live period moves only on an update or a full reset;
- a restart command leaves the count and the waveforms at zero;
- the overflow flag stays set until it is cleared by a write;
- in dual-slope mode every counting step moves the count by exactly one;
- in single-slope mode the count never passes the effective period.

Other behaviour depends on a whole sequence, so only the bench's scenarios show it:

- the exact shape of the single-slope and dual-slope waveforms;
- the values recorded by frequency capture and pulse-width capture;
- the clamp of short periods in the PWM modes;
- the rule that capture buffers are not copied at an update.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 4;
    localparam int CTRL_W = 9;
    localparam int MAX_CH = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_CMD  = 4'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 4'd2;
    localparam logic [ADDR_W-1:0] A_PER  = 4'd3;
    localparam logic [ADDR_W-1:0] A_PERB = 4'd4;
    localparam logic [ADDR_W-1:0] A_CC0  = 4'd5;
    localparam logic [ADDR_W-1:0] A_CCB0 = 4'd9;
    localparam logic [ADDR_W-1:0] A_FLAG = 4'd13;

    typedef enum logic [1:0] {
        MODE_FREE = 2'd0,
        MODE_SS   = 2'd1,
        MODE_DS   = 2'd2,
        MODE_RSV  = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        CAP_OFF  = 2'd0,
        CAP_FREQ = 2'd1,
        CAP_PW   = 2'd2,
        CAP_RSV  = 2'd3
    } cap_mode_e;

    typedef struct packed {
        logic [MAX_CH-1:0] capen;
        cap_mode_e         cap;
        logic              down;
        tmr_mode_e         mode;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{capen: 4'b0, cap: CAP_OFF, down: 1'b0, mode: MODE_FREE};
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst,
    input  logic         restart,
    input  logic         evt_restart,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  tmr_mode_e    mode,
    input  logic         down_cfg,
    input  logic [W-1:0] per_eff,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cnt_nxt_o,
    output logic         stepped_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         falling;
    } cnt_st_t;

    cnt_st_t s_d, s_q;
    logic    wrap_d, step_d;

    always_comb begin
        s_d    = s_q;
        wrap_d = 1'b0;
        step_d = 1'b0;
        if (srst || restart) begin
            s_d.cnt     = '0;
            s_d.falling = 1'b0;
        end else if (evt_restart) begin
            s_d.cnt     = tick ? ONE : '0;
            s_d.falling = 1'b0;
        end else if (load) begin
            s_d.cnt = load_val;
        end else if (tick) begin
            step_d = 1'b1;
            unique case (mode)
                MODE_DS: begin
                    if (!s_q.falling) begin
                        if (s_q.cnt >= per_eff) begin
                            s_d.falling = 1'b1;
                            s_d.cnt     = per_eff - ONE;
                        end else begin
                            s_d.cnt = s_q.cnt + ONE;
                        end
                    end else if (s_q.cnt == '0) begin
                        s_d.falling = 1'b0;
                        s_d.cnt     = ONE;
                        wrap_d      = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt - ONE;
                    end
                end
                MODE_FREE: begin
                    if (down_cfg) begin
                        if (s_q.cnt == '0) begin
                            s_d.cnt = per_eff;
                            wrap_d  = 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt - ONE;
                        end
                    end else if (s_q.cnt >= per_eff) begin
                        s_d.cnt = '0;
                        wrap_d  = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + ONE;
                    end
                end
                default: begin
                    if (s_q.cnt >= per_eff) begin
                        s_d.cnt = '0;
                        wrap_d  = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + ONE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o     = s_q.cnt;
    assign cnt_nxt_o = s_d.cnt;
    assign stepped_o = step_d;
    assign wrap_o    = wrap_d;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst,
    input  logic         restart,
    input  logic         wr_buf,
    input  logic [W-1:0] wr_data,
    input  logic         upd,
    input  logic         cap_on,
    input  logic         cap_take,
    input  logic [W-1:0] cnt_q,
    input  logic [W-1:0] cnt_nxt,
    input  logic         stepped,
    input  tmr_mode_e    mode,
    input  logic         flag_clr,
    output logic [W-1:0] cc_o,
    output logic [W-1:0] buf_o,
    output logic         bv_o,
    output logic         wave_o,
    output logic         flag_o
);
    typedef struct packed {
        logic [W-1:0] cc;
        logic [W-1:0] shadow;
        logic         bv;
        logic         wave;
        logic         flag;
    } ch_st_t;

    ch_st_t       s_d, s_q;
    logic [W-1:0] cc_new;
    logic         xfer, match;

    always_comb begin
        s_d    = s_q;
        xfer   = upd && s_q.bv && !cap_on;
        cc_new = xfer ? s_q.shadow : s_q.cc;
        s_d.cc = cc_new;
        if (xfer) s_d.bv = 1'b0;

        if (cap_on && cap_take) begin
            s_d.shadow = cnt_q;
            s_d.bv     = 1'b1;
        end else if (wr_buf) begin
            s_d.shadow = wr_data;
            s_d.bv     = 1'b1;
        end

        match = stepped && !cap_on && (cnt_nxt == cc_new);

        if (flag_clr) s_d.flag = 1'b0;
        if (match || (cap_on && cap_take)) s_d.flag = 1'b1;

        if (mode == MODE_SS) begin
            if (match)                           s_d.wave = 1'b0;
            else if (stepped && cnt_nxt == '0)   s_d.wave = 1'b1;
        end else if (match) begin
            s_d.wave = ~s_q.wave;
        end

        if (restart) s_d.wave = 1'b0;
        if (srst)    s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cc_o   = s_q.cc;
    assign buf_o  = s_q.shadow;
    assign bv_o   = s_q.bv;
    assign wave_o = s_q.wave;
    assign flag_o = s_q.flag;
endmodule

// File: rtl/dbuf_timer.sv
module dbuf_timer
    import tmr_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cap_evt,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [3:0]        rd_addr,
    output logic [W-1:0]      rd_data,
    output logic [NCH-1:0]    wave_o,
    output logic              ovf_irq,
    output logic [NCH-1:0]    ch_irq
);
    localparam logic [W-1:0] PER_MIN  = W'(3);
    localparam logic [W-1:0] PER_INIT = '1;
    localparam int           FL_PBV   = 1 + MAX_CH;
    localparam int           FL_CBV   = FL_PBV + 1;

    typedef struct packed {
        ctrl_t        ctrl;
        logic [W-1:0] per;
        logic [W-1:0] perb;
        logic         perbv;
        logic         ovf;
        logic         evt;
    } top_st_t;

    top_st_t        s_d, s_q;
    logic           cmd_wr, srst, restart, cmd_upd, upd, flag_wr;
    logic           rise, fall, cap_any, evt_restart, cap_take, pwm;
    logic [W-1:0]   per_eff, cnt_w, cnt_nxt_w;
    logic           stepped, wrap;
    logic [W-1:0]   cc_w  [NCH];
    logic [W-1:0]   buf_w [NCH];
    logic [NCH-1:0] bv_w, flag_w;

    always_comb begin
        cmd_wr      = wr_en && (wr_addr == A_CMD);
        srst        = cmd_wr && wr_data[2];
        restart     = cmd_wr && wr_data[1];
        cmd_upd     = cmd_wr && wr_data[0];
        upd         = wrap || cmd_upd;
        flag_wr     = wr_en && (wr_addr == A_FLAG);
        rise        = cap_evt && !s_q.evt;
        fall        = !cap_evt && s_q.evt;
        cap_any     = (s_q.ctrl.cap == CAP_FREQ) || (s_q.ctrl.cap == CAP_PW);
        evt_restart = cap_any && rise;
        cap_take    = ((s_q.ctrl.cap == CAP_FREQ) && rise) ||
                      ((s_q.ctrl.cap == CAP_PW) && fall);
        pwm         = (s_q.ctrl.mode == MODE_SS) || (s_q.ctrl.mode == MODE_DS);
        per_eff     = (pwm && s_q.per < PER_MIN) ? PER_MIN : s_q.per;
    end

    always_comb begin
        s_d     = s_q;
        s_d.evt = cap_evt;
        if (upd && s_q.perbv) begin
            s_d.per   = s_q.perb;
            s_d.perbv = 1'b0;
        end
        if (wr_en && wr_addr == A_PER) begin
            s_d.perb  = wr_data;
            s_d.perbv = 1'b1;
        end
        if (wr_en && wr_addr == A_CTRL) s_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
        if (flag_wr && wr_data[0]) s_d.ovf = 1'b0;
        if (wrap) s_d.ovf = 1'b1;
        if (srst) begin
            s_d.ctrl  = CTRL_RST;
            s_d.per   = PER_INIT;
            s_d.perb  = '0;
            s_d.perbv = 1'b0;
            s_d.ovf   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ctrl  <= CTRL_RST;
            s_q.per   <= PER_INIT;
            s_q.perb  <= '0;
            s_q.perbv <= 1'b0;
            s_q.ovf   <= 1'b0;
            s_q.evt   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    tmr_counter #(.W(W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .srst        (srst),
        .restart     (restart),
        .evt_restart (evt_restart),
        .load        (wr_en && wr_addr == A_CNT),
        .load_val    (wr_data),
        .tick        (tick),
        .mode        (s_q.ctrl.mode),
        .down_cfg    (s_q.ctrl.down),
        .per_eff     (per_eff),
        .cnt_o       (cnt_w),
        .cnt_nxt_o   (cnt_nxt_w),
        .stepped_o   (stepped),
        .wrap_o      (wrap)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_channel #(.W(W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .srst     (srst),
            .restart  (restart),
            .wr_buf   (wr_en && wr_addr == A_CC0 + ADDR_W'(g)),
            .wr_data  (wr_data),
            .upd      (upd),
            .cap_on   (cap_any && s_q.ctrl.capen[g]),
            .cap_take (cap_take),
            .cnt_q    (cnt_w),
            .cnt_nxt  (cnt_nxt_w),
            .stepped  (stepped),
            .mode     (s_q.ctrl.mode),
            .flag_clr (flag_wr && wr_data[1+g]),
            .cc_o     (cc_w[g]),
            .buf_o    (buf_w[g]),
            .bv_o     (bv_w[g]),
            .wave_o   (wave_o[g]),
            .flag_o   (flag_w[g])
        );
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: rd_data[CTRL_W-1:0] = s_q.ctrl;
            A_CNT:  rd_data = cnt_w;
            A_PER:  rd_data = s_q.per;
            A_PERB: rd_data = s_q.perb;
            A_FLAG: begin
                rd_data[0]      = s_q.ovf;
                rd_data[FL_PBV] = s_q.perbv;
                for (int i = 0; i < NCH; i++) begin
                    rd_data[1+i]      = flag_w[i];
                    rd_data[FL_CBV+i] = bv_w[i];
                end
            end
            default: ;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == A_CC0 + ADDR_W'(i))  rd_data = cc_w[i];
            if (rd_addr == A_CCB0 + ADDR_W'(i)) rd_data = buf_w[i];
        end
    end

    assign ovf_irq = s_q.ovf;
    assign ch_irq  = flag_w;
endmodule

// File: rtl/dbuf_timer_chk.sv
module dbuf_timer_chk
    import tmr_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [3:0]     wr_addr,
    input logic           srst,
    input logic           restart,
    input logic           upd,
    input logic [W-1:0]   per_q,
    input logic [W-1:0]   per_eff,
    input logic [W-1:0]   cnt,
    input logic           stepped,
    input logic           wrap,
    input tmr_mode_e      mode,
    input logic [NCH-1:0] wave_o,
    input logic           ovf_irq
);
    // R4: live period changes only at an update or a full reset
    a_r4_per_only_at_update: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(per_q) |-> $past(upd || srst));

    // R5: restart leaves count and waveforms at zero
    a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0) && (wave_o == '0));

    // R9: overflow flag is sticky until a flags write
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq && !(wr_en && wr_addr == A_FLAG) && !srst |=> ovf_irq);

    // R2: a wrap always raises the overflow flag
    a_r2_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_irq);

    // R7: dual-slope steps move the count by one
    a_r7_dual_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DS) && stepped |=>
            (cnt == $past(cnt) + W'(1)) || (cnt == $past(cnt) - W'(1)));

    // R6: single-slope count stays within the effective period
    a_r6_ss_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SS) && stepped |=> cnt <= $past(per_eff));
endmodule

bind dbuf_timer dbuf_timer_chk #(.W(W), .NCH(NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .srst    (srst),
    .restart (restart),
    .upd     (upd),
    .per_q   (s_q.per),
    .per_eff (per_eff),
    .cnt     (cnt_w),
    .stepped (stepped),
    .wrap    (wrap),
    .mode    (s_q.ctrl.mode),
    .wave_o  (wave_o),
    .ovf_irq (ovf_irq)
);

// File: tb/dbuf_timer_test.sv
module dbuf_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 16;
    localparam int NCH = 4;

    localparam int NV = 4;
    localparam int VT_TICKS [NV] = '{3, 2, 1, 4};
    localparam int VT_CNT   [NV] = '{3, 5, 0, 4};
    localparam int VT_OVF   [NV] = '{0, 0, 1, 1};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick = 1'b0;
    logic           cap_evt = 1'b0;
    logic           wr_en = 1'b0;
    logic [3:0]     wr_addr = '0;
    logic [W-1:0]   wr_data = '0;
    logic [3:0]     rd_addr = '0;
    logic [W-1:0]   rd_data;
    logic [NCH-1:0] wave_o;
    logic           ovf_irq;
    logic [NCH-1:0] ch_irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbuf_timer #(.W(W), .NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cap_evt(cap_evt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wave_o(wave_o), .ovf_irq(ovf_irq), .ch_irq(ch_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [W-1:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick = 1'b1;
            repeat (n) @(posedge clk);
            #1 tick = 1'b0;
        end
    endtask

    task automatic chk_reg(input string tag, input logic [3:0] a, input logic [W-1:0] exp);
        rd_addr = a;
        #1;
        chk(tag, 32'(rd_data), 32'(exp));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        chk_reg("R1 count", 4'd2, 16'h0);
        chk_reg("R1 period", 4'd3, 16'hFFFF);
        chk_reg("R1 compare0", 4'd5, 16'h0);
        chk_reg("R1 flags", 4'd13, 16'h0);
        chk_reg("R1 control", 4'd0, 16'h0);
        chk("R1 waves", 32'(wave_o), 32'h0);

        // R3 buffered writes
        wr(4'd3, 16'd5);
        chk_reg("R3 period live kept", 4'd3, 16'hFFFF);
        chk_reg("R3 period buffer", 4'd4, 16'd5);
        wr(4'd5, 16'd2);
        chk_reg("R3 compare0 live kept", 4'd5, 16'h0);
        chk_reg("R3 compare0 buffer", 4'd9, 16'd2);
        chk_reg("R3 valid flags", 4'd13, 16'h0060);

        // R4 update command, R5 command reads zero
        wr(4'd1, 16'd1);
        chk_reg("R4 period after update", 4'd3, 16'd5);
        chk_reg("R4 compare0 after update", 4'd5, 16'd2);
        chk_reg("R4 valid cleared", 4'd13, 16'h0);
        chk_reg("R5 command reads zero", 4'd1, 16'h0);

        // R2 free counting up, table-driven
        for (int i = 0; i < NV; i++) begin
            ticks(VT_TICKS[i]);
            chk_reg($sformatf("R2 up count vec%0d", i), 4'd2, W'(VT_CNT[i]));
            chk($sformatf("R2 overflow vec%0d", i), 32'(ovf_irq), 32'(VT_OVF[i]));
        end
        // R9 flags: channel 0 matched at count 2
        chk("R9 ch0 flag set", 32'(ch_irq[0]), 32'h1);
        wr(4'd13, 16'h0002);
        chk("R9 ch0 flag cleared", 32'(ch_irq[0]), 32'h0);
        chk("R9 ovf kept", 32'(ovf_irq), 32'h1);
        wr(4'd13, 16'h0001);
        chk("R9 ovf cleared", 32'(ovf_irq), 32'h0);

        // R2 counting down
        wr(4'd0, 16'h0004);
        ticks(4);
        chk_reg("R2 down to zero", 4'd2, 16'd0);
        chk("R2 no underflow yet", 32'(ovf_irq), 32'h0);
        ticks(1);
        chk_reg("R2 underflow loads period", 4'd2, 16'd5);
        chk("R2 underflow flag", 32'(ovf_irq), 32'h1);

        // R4 update at wrap
        wr(4'd0, 16'h0000);
        wr(4'd3, 16'd7);
        ticks(1);
        chk_reg("R4 wrap to zero", 4'd2, 16'd0);
        chk_reg("R4 period taken at wrap", 4'd3, 16'd7);
        ticks(7);
        chk_reg("R4 new period used", 4'd2, 16'd7);

        // R5 restart and reset commands
        wr(4'd2, 16'd3);
        chk_reg("R5 count loaded", 4'd2, 16'd3);
        wr(4'd1, 16'h0002);
        chk_reg("R5 restart clears count", 4'd2, 16'd0);
        wr(4'd0, 16'h0001);
        wr(4'd1, 16'h0004);
        chk_reg("R5 reset control", 4'd0, 16'h0);
        chk_reg("R5 reset period", 4'd3, 16'hFFFF);
        chk_reg("R5 reset compare0", 4'd5, 16'h0);

        // R6 single-slope PWM
        wr(4'd3, 16'd5);
        wr(4'd5, 16'd2);
        wr(4'd7, 16'd7);
        wr(4'd1, 16'h0001);
        wr(4'd0, 16'h0001);
        ticks(2);
        chk("R6 ch0 low at match", 32'(wave_o[0]), 32'h0);
        ticks(4);
        chk_reg("R6 wrapped to bottom", 4'd2, 16'd0);
        chk("R6 waves at bottom", 32'(wave_o), 32'h5);
        ticks(1);
        chk("R6 ch0 high after bottom", 32'(wave_o[0]), 32'h1);
        ticks(1);
        chk("R6 ch0 low at compare", 32'(wave_o[0]), 32'h0);
        chk("R6 ch2 above period stays high", 32'(wave_o[2]), 32'h1);

        // R8 minimum period in PWM
        wr(4'd1, 16'h0004);
        wr(4'd3, 16'd1);
        wr(4'd1, 16'h0001);
        wr(4'd0, 16'h0001);
        ticks(3);
        chk_reg("R8 clamped count reaches 3", 4'd2, 16'd3);
        ticks(1);
        chk_reg("R8 wrap after 3", 4'd2, 16'd0);
        wr(4'd0, 16'h0000);
        wr(4'd1, 16'h0002);
        ticks(2);
        chk_reg("R8 free count not clamped", 4'd2, 16'd0);

        // R7 dual-slope PWM with update at bottom
        wr(4'd1, 16'h0004);
        wr(4'd3, 16'd4);
        wr(4'd5, 16'd2);
        wr(4'd1, 16'h0001);
        wr(4'd0, 16'h0002);
        ticks(2);
        chk("R7 ch0 toggles up", 32'(wave_o[0]), 32'h1);
        ticks(2);
        chk_reg("R7 at top", 4'd2, 16'd4);
        wr(4'd3, 16'd6);
        ticks(1);
        chk_reg("R7 turns down", 4'd2, 16'd3);
        ticks(1);
        chk("R7 ch0 toggles down", 32'(wave_o[0]), 32'h0);
        ticks(2);
        chk_reg("R7 at bottom", 4'd2, 16'd0);
        chk("R7 no ovf before bottom turn", 32'(ovf_irq), 32'h0);
        chk_reg("R7 period still old", 4'd3, 16'd4);
        ticks(1);
        chk_reg("R7 leaves bottom", 4'd2, 16'd1);
        chk("R7 ovf at bottom", 32'(ovf_irq), 32'h1);
        chk_reg("R7 period updated at bottom", 4'd3, 16'd6);

        // R10 frequency capture, period 7 ticks
        wr(4'd1, 16'h0004);
        wr(4'd0, 16'd40);
        cap_evt = 1'b1; tick = 1'b1;
        repeat (2) @(posedge clk);
        #1 cap_evt = 1'b0;
        repeat (5) @(posedge clk);
        #1 cap_evt = 1'b1;
        @(posedge clk);
        #1 tick = 1'b0;
        chk_reg("R10 captured period", 4'd9, 16'd7);
        chk_reg("R10 counter restarted", 4'd2, 16'd1);
        chk_reg("R10 flags", 4'd13, 16'h0042);
        wr(4'd1, 16'h0001);
        chk_reg("R12 capture buffer not transferred", 4'd5, 16'h0);
        chk_reg("R12 capture valid kept", 4'd13, 16'h0042);

        // R11 pulse-width capture, high for 4 ticks
        cap_evt = 1'b0;
        @(posedge clk); #1;
        wr(4'd1, 16'h0004);
        wr(4'd0, 16'd80);
        cap_evt = 1'b1; tick = 1'b1;
        repeat (4) @(posedge clk);
        #1 cap_evt = 1'b0;
        @(posedge clk);
        #1 tick = 1'b0;
        chk_reg("R11 captured width", 4'd10, 16'd4);
        chk("R11 ch1 flag", 32'(ch_irq[1]), 32'h1);
        chk_reg("R11 flags", 4'd13, 16'h0084);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule